// File: doc/BRIEF.md
# Transmit Power-Mode Controller

This block turns two external active-low control pins (shutdown and idle) and a 16-bit operating-control word into separate power enables for the sub-blocks of a transmitter: the synthesizer PLL, the VCO, the baseband filter, and the modulator/upconverter/driver chain. It also drives a filter-bypass select, three level/bias selects, and a two-bit indicator of the current power mode.

Each pin passes through a two-flop synchroniser and a three-sample majority filter before the mode decode uses it. The shutdown sources take priority over idle, and idle takes priority over full power. When idle takes effect, the PLL and VCO enable bits are captured and held, so later writes to those bits cannot disturb the synthesizer until idle is released. All outputs come from one register stage, so a control-word update cannot make them glitch.

Top module: `txpm_ctrl`

## Requirements
- R1: While the filtered shutdown pin is low, pll_en, vco_en, filt_en, chain_en and filt_bypass are all 0 and pwr_mode is OFF (2'b00), whatever the control word holds.
- R2: Control-word bit 0 at 0 forces the same all-off state as R1.
- R3: With both shutdown sources inactive and the filtered idle pin low, pwr_mode is IDLE (2'b01) and chain_en is 0.
- R4: In IDLE, pll_en and vco_en equal control bits 4 and 5 as they stood on the clock edge where the filtered idle pin fell. Later writes to those bits have no effect until idle is released, and then live control resumes.
- R5: In IDLE, filt_en is 1 only when bit 1 (keep filter in idle) and bit 3 (filter enable) are both 1.
- R6: In ACTIVE (pwr_mode 2'b10: no shutdown, idle pin high), pll_en = bit 4, vco_en = bit 5, filt_en = bit 3 and chain_en = bit 6.
- R7: filt_bypass is the inverse of bit 3 in IDLE and ACTIVE, and 0 in OFF.
- R8: level_hi = bit 8, predrv_nom = bit 9 and outbias_boost = bit 10 in every mode.
- R9: A pin pulse lasting one clock cycle has no effect on any output. A lasting pin change reaches the outputs on the 6th rising clock edge after it is set up.
- R10: A control-word change reaches the outputs on the next rising clock edge.
- R11: While rst_n is low, every output is 0 and pwr_mode is OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shdn_pin_n | input | 1 | Asynchronous shutdown pin, active low |
| idle_pin_n | input | 1 | Asynchronous idle pin, active low |
| ctrl_word | input | 16 | Operating-control word |
| pll_en | output | 1 | PLL power enable |
| vco_en | output | 1 | VCO power enable |
| filt_en | output | 1 | Baseband filter power enable |
| chain_en | output | 1 | Modulator/upconverter/driver enable |
| filt_bypass | output | 1 | Route baseband around the filter |
| level_hi | output | 1 | High maximum output level select |
| predrv_nom | output | 1 | Nominal predriver bias (0 = reduced) |
| outbias_boost | output | 1 | Boosted output bias |
| pwr_mode | output | 2 | 00 OFF, 01 IDLE, 10 ACTIVE |

## Verification
A change on the control word is due one edge later. A pin change is due six edges later: two synchroniser flops, two samples to win the majority window, the filtered-pin register, and the output register. The latency checks sample just after the 5th edge, expecting the old value, and just after the 6th, expecting the new one. Random and directed steady-state checks wait eight cycles after each stimulus and sample on the falling clock edge. The bench updates its own model of the held synthesizer bits only when it drives the idle pin from high to low.

// File: rtl/txpm_pkg.sv
package txpm_pkg;
  localparam int unsigned CTRL_W = 16;

  localparam int unsigned B_RUN      = 0;
  localparam int unsigned B_IDLEFILT = 1;
  localparam int unsigned B_FILT     = 3;
  localparam int unsigned B_PLL      = 4;
  localparam int unsigned B_VCO      = 5;
  localparam int unsigned B_CHAIN    = 6;
  localparam int unsigned B_LVL      = 8;
  localparam int unsigned B_PRE      = 9;
  localparam int unsigned B_BOOST    = 10;

  typedef enum logic [1:0] {
    PM_OFF    = 2'b00,
    PM_IDLE   = 2'b01,
    PM_ACTIVE = 2'b10
  } pm_mode_e;

  typedef struct packed {
    pm_mode_e mode;
    logic     pll;
    logic     vco;
    logic     filt;
    logic     chain;
    logic     byp;
    logic     lvl;
    logic     pre;
    logic     boost;
  } pm_out_t;

  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  function automatic pm_mode_e pick_mode(input logic run_ok, input logic awake);
    if (!run_ok)    return PM_OFF;
    else if (!awake) return PM_IDLE;
    else            return PM_ACTIVE;
  endfunction
endpackage

// File: rtl/txpm_pin_filter.sv
module txpm_pin_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        RST_LVL     = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  output logic pin_clean,
  output logic pin_next
);
  import txpm_pkg::*;

  localparam int unsigned WIN = 3;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [WIN-1:0]         win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= {SYNC_STAGES{RST_LVL}};
      win_q     <= {WIN{RST_LVL}};
      pin_clean <= RST_LVL;
    end else begin
      sync_q    <= {sync_q[SYNC_STAGES-2:0], pin_raw};
      win_q     <= {win_q[WIN-2:0], sync_q[SYNC_STAGES-1]};
      pin_clean <= pin_next;
    end
  end

  assign pin_next = vote3(win_q);
endmodule

// File: rtl/txpm_synth_hold.sv
module txpm_synth_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic pll_live,
  input  logic vco_live,
  output logic pll_held,
  output logic vco_held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_held <= 1'b0;
      vco_held <= 1'b0;
    end else if (capture) begin
      pll_held <= pll_live;
      vco_held <= vco_live;
    end
  end
endmodule

// File: rtl/txpm_mode_decode.sv
module txpm_mode_decode (
  input  logic                           shdn_ok,
  input  logic                           awake,
  input  logic [txpm_pkg::CTRL_W-1:0]    ctrl,
  input  logic                           pll_held,
  input  logic                           vco_held,
  output txpm_pkg::pm_out_t              dec
);
  import txpm_pkg::*;

  logic     run_ok;
  pm_mode_e mode;

  assign run_ok = shdn_ok & ctrl[B_RUN];
  assign mode   = pick_mode(run_ok, awake);

  always_comb begin
    dec       = '0;
    dec.mode  = mode;
    dec.lvl   = ctrl[B_LVL];
    dec.pre   = ctrl[B_PRE];
    dec.boost = ctrl[B_BOOST];
    unique case (mode)
      PM_IDLE: begin
        dec.pll  = pll_held;
        dec.vco  = vco_held;
        dec.filt = ctrl[B_IDLEFILT] & ctrl[B_FILT];
        dec.byp  = ~ctrl[B_FILT];
      end
      PM_ACTIVE: begin
        dec.pll   = ctrl[B_PLL];
        dec.vco   = ctrl[B_VCO];
        dec.filt  = ctrl[B_FILT];
        dec.chain = ctrl[B_CHAIN];
        dec.byp   = ~ctrl[B_FILT];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/txpm_ctrl.sv
module txpm_ctrl #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        shdn_pin_n,
  input  logic                        idle_pin_n,
  input  logic [txpm_pkg::CTRL_W-1:0] ctrl_word,
  output logic                        pll_en,
  output logic                        vco_en,
  output logic                        filt_en,
  output logic                        chain_en,
  output logic                        filt_bypass,
  output logic                        level_hi,
  output logic                        predrv_nom,
  output logic                        outbias_boost,
  output logic [1:0]                  pwr_mode
);
  import txpm_pkg::*;

  localparam int unsigned NPIN = 2;
  localparam int unsigned P_SHDN = 0;
  localparam int unsigned P_IDLE = 1;

  logic [NPIN-1:0] pin_raw, pin_clean, pin_next;
  logic            idle_fall_evt;
  logic            pll_held, vco_held;
  pm_out_t         dec, out_q;

  assign pin_raw[P_SHDN] = shdn_pin_n;
  assign pin_raw[P_IDLE] = idle_pin_n;

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    txpm_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_flt (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_raw  (pin_raw[g]),
      .pin_clean(pin_clean[g]),
      .pin_next (pin_next[g])
    );
  end

  assign idle_fall_evt = pin_clean[P_IDLE] & ~pin_next[P_IDLE];

  txpm_synth_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (idle_fall_evt),
    .pll_live(ctrl_word[B_PLL]),
    .vco_live(ctrl_word[B_VCO]),
    .pll_held(pll_held),
    .vco_held(vco_held)
  );

  txpm_mode_decode u_dec (
    .shdn_ok (pin_clean[P_SHDN]),
    .awake   (pin_clean[P_IDLE]),
    .ctrl    (ctrl_word),
    .pll_held(pll_held),
    .vco_held(vco_held),
    .dec     (dec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= dec;
  end

  assign pwr_mode      = out_q.mode;
  assign pll_en        = out_q.pll;
  assign vco_en        = out_q.vco;
  assign filt_en       = out_q.filt;
  assign chain_en      = out_q.chain;
  assign filt_bypass   = out_q.byp;
  assign level_hi      = out_q.lvl;
  assign predrv_nom    = out_q.pre;
  assign outbias_boost = out_q.boost;
endmodule

// File: rtl/txpm_ctrl_chk.sv
module txpm_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] ctrl_word,
  input logic        idle_fall_evt,
  input logic        pll_held,
  input logic        vco_held,
  input logic        pll_en,
  input logic        vco_en,
  input logic        filt_en,
  input logic        chain_en,
  input logic        filt_bypass,
  input logic        level_hi,
  input logic        predrv_nom,
  input logic        outbias_boost,
  input logic [1:0]  pwr_mode
);
  assert_off_all_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b00) |-> (!pll_en && !vco_en && !filt_en && !chain_en && !filt_bypass));

  assert_runbit_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctrl_word[0]) |-> (pwr_mode == 2'b00));

  assert_idle_chain_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b01) |-> !chain_en);

  assert_idle_synth_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b01 && $past(pwr_mode) == 2'b01) |-> ($stable(pll_en) && $stable(vco_en)));

  assert_fall_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idle_fall_evt |=> (pll_held == $past(ctrl_word[4]) && vco_held == $past(ctrl_word[5])));

  assert_idle_filter_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b01) |-> (filt_en == ($past(ctrl_word[1]) & $past(ctrl_word[3]))));

  assert_active_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b10) |-> (pll_en == $past(ctrl_word[4]) && vco_en == $past(ctrl_word[5]) &&
                             filt_en == $past(ctrl_word[3]) && chain_en == $past(ctrl_word[6])));

  assert_bias_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (level_hi == $past(ctrl_word[8]) && predrv_nom == $past(ctrl_word[9]) &&
                      outbias_boost == $past(ctrl_word[10])));
endmodule

bind txpm_ctrl txpm_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctrl_word    (ctrl_word),
  .idle_fall_evt(idle_fall_evt),
  .pll_held     (pll_held),
  .vco_held     (vco_held),
  .pll_en       (pll_en),
  .vco_en       (vco_en),
  .filt_en      (filt_en),
  .chain_en     (chain_en),
  .filt_bypass  (filt_bypass),
  .level_hi     (level_hi),
  .predrv_nom   (predrv_nom),
  .outbias_boost(outbias_boost),
  .pwr_mode     (pwr_mode)
);

// File: tb/sim_txpm_ctrl.sv
module sim_txpm_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        shdn_pin_n = 1'b1;
  logic        idle_pin_n = 1'b1;
  logic [15:0] ctrl_word = 16'h0000;
  logic        pll_en, vco_en, filt_en, chain_en, filt_bypass;
  logic        level_hi, predrv_nom, outbias_boost;
  logic [1:0]  pwr_mode;

  int checks = 0;
  int bad = 0;
  logic hp = 1'b0, hv = 1'b0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  txpm_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .shdn_pin_n(shdn_pin_n), .idle_pin_n(idle_pin_n),
    .ctrl_word(ctrl_word), .pll_en(pll_en), .vco_en(vco_en), .filt_en(filt_en),
    .chain_en(chain_en), .filt_bypass(filt_bypass), .level_hi(level_hi),
    .predrv_nom(predrv_nom), .outbias_boost(outbias_boost), .pwr_mode(pwr_mode)
  );

  // {mode[1:0], pll, vco, filt, chain, bypass, level, predrv, boost}
  function automatic logic [9:0] model(input logic sh, input logic id,
                                       input logic [15:0] c, input logic p, input logic v);
    logic [9:0] r;
    r = '0;
    r[2:0] = {c[8], c[9], c[10]};
    if (!sh || !c[0]) r[9:8] = 2'b00;
    else if (!id) begin
      r[9:8] = 2'b01; r[7] = p; r[6] = v; r[5] = c[1] & c[3]; r[4] = 1'b0; r[3] = ~c[3];
    end else begin
      r[9:8] = 2'b10; r[7] = c[4]; r[6] = c[5]; r[5] = c[3]; r[4] = c[6]; r[3] = ~c[3];
    end
    return r;
  endfunction

  function automatic logic [9:0] got();
    return {pwr_mode, pll_en, vco_en, filt_en, chain_en, filt_bypass,
            level_hi, predrv_nom, outbias_boost};
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic apply(input logic sh, input logic id, input logic [15:0] c, input string req);
    @(negedge clk);
    if (idle_pin_n && !id) begin hp = c[4]; hv = c[5]; end
    shdn_pin_n = sh; idle_pin_n = id; ctrl_word = c;
    repeat (8) @(posedge clk);
    @(negedge clk);
    check(req, got(), model(sh, id, c, hp, hv));
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    ctrl_word = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 reset", got(), 10'b0);
    rst_n = 1'b1;

    // directed: full power, then each shutdown source
    apply(1, 1, 16'h0779, "R6 active all on");
    apply(0, 1, 16'h0779, "R1 pin shutdown");
    apply(1, 1, 16'h0778, "R2 run bit off");
    apply(1, 1, 16'h0571, "R7 bypass when filter bit clear");

    // R4: hold across idle, writes ignored
    apply(1, 1, 16'h001B, "R6 pll on vco off");
    apply(1, 0, 16'h001B, "R4 idle capture");
    apply(1, 0, 16'h002B, "R4 write during idle ignored");
    apply(1, 0, 16'h0029, "R5 filter off in idle when keep bit clear");
    apply(1, 1, 16'h002B, "R4 live control after idle");
    apply(1, 0, 16'h0071, "R3 idle chain off");

    // R10: control latency one edge
    apply(1, 1, 16'h0079, "R6 setup");
    @(negedge clk); ctrl_word = 16'h0131;
    @(posedge clk); @(negedge clk);
    check("R10 ctrl next edge", got(), model(1, 1, 16'h0131, hp, hv));

    // R9: single-cycle shutdown pulse rejected
    @(negedge clk); shdn_pin_n = 1'b0;
    @(negedge clk); shdn_pin_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check("R9 pulse ignored", got(), model(1, 1, 16'h0131, hp, hv));
    end

    // R9: lasting change lands on the 6th edge
    @(negedge clk); idle_pin_n = 1'b0; hp = ctrl_word[4]; hv = ctrl_word[5];
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R9 not yet after 5 edges", got(), model(1, 1, 16'h0131, hp, hv));
    @(posedge clk); @(negedge clk);
    check("R9 due at 6th edge", got(), model(1, 0, 16'h0131, hp, hv));

    // random mix; bias bits (R8) checked in every call
    for (int n = 0; n < 120; n++) begin
      logic sh, id;
      logic [15:0] c;
      sh = ($urandom % 5) != 0;
      id = ($urandom % 5) >= 2;
      c  = 16'($urandom);
      c[0] = ($urandom % 5) != 0;
      apply(sh, id, c, "R8 random mode mix");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule